// File: doc/BRIEF.md
# Paged Outbound Address Translator

This block widens the address of an outbound memory-mapped request before it is turned into a link-layer packet. A small page table, filled in at run time through a register-style control port, holds one base per page. Some mid-order bits of the request address choose an entry. The entry's base replaces the upper part of the address, and the low offset inside the page is passed through unchanged. Each entry also carries a 2-bit space code, which leaves the block alongside the translated address and tells the packet builder whether to use 32-bit or 64-bit addressing.

The request path has one register stage with a valid/ready handshake. A two-state controller governs it. In `ST_EMPTY` the stage holds nothing and `in_ready` is high. LOAD moves `ST_EMPTY` to `ST_FULL` when a request is accepted. In `ST_FULL` the stage presents `out_valid` and `in_ready` follows `out_ready`. From `ST_FULL` there are three transitions. DRAIN returns to `ST_EMPTY` when the output is taken and no new request arrives. STREAM stays in `ST_FULL` when the output is taken and a new request is loaded in the same cycle. STALL stays in `ST_FULL` and holds everything while `out_ready` is low.

When the parameter `BYPASS` is set, the block is built for 64-bit input addresses. In that case the table plays no part in the request path and addresses pass straight through.

Top module: `pot_translator`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high, and every table word reads back as zero.
- R2: Output address bits [PAGE_BITS-1:0] equal the same bits of the accepted input address.
- R3: Input bits [PAGE_BITS+IDX_BITS-1:PAGE_BITS] select the entry, and output bits [63:PAGE_BITS] equal that entry's base bits. Input bits above PAGE_BITS+IDX_BITS-1 have no effect on the output.
- R4: `out_space` equals the 2-bit space code stored in the selected entry.
- R5: `cfg_addr` bit 0 selects the word and `cfg_addr[IDX_BITS:1]` selects the entry. A word value of 1 is the high word, which holds base bits [63:32]. A word value of 0 is the low word: it holds base bits [31:PAGE_BITS] in bits [31:PAGE_BITS] and the space code in bits [1:0], and its bits [PAGE_BITS-1:2] are not stored and read back as zero. A read returns its data with `cfg_rvalid` high on the cycle after `cfg_rd`.
- R6: A read and a write to the same word in the same cycle return the contents from before the write.
- R7: A request accepted on one clock edge appears on `out_valid`/`out_addr`/`out_space` after that edge, with one cycle of latency.
- R8: `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output address and space stay unchanged.
- R9: A table write to an entry in the same cycle that a request using that entry is accepted does not affect that request. It affects the next request.
- R10: With `BYPASS`=1 and `IN_AW`=64, `out_addr` equals the accepted input address and `out_space` is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request address valid |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | IN_AW | Request address |
| out_valid | output | 1 | Translated request valid |
| out_ready | input | 1 | Downstream accepts translated request |
| out_addr | output | 64 | Translated address |
| out_space | output | 2 | Space code of the translated request |
| cfg_wr | input | 1 | Table word write strobe |
| cfg_rd | input | 1 | Table word read strobe |
| cfg_addr | input | IDX_BITS+1 | Entry index and word select |
| cfg_wdata | input | 32 | Table write data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |

## Verification
The bench covers several cases that a flawed design would get wrong:
- **Same-cycle table update and request.** A design that forwards the write into the lookup would emit the new base one request too early.
- **Stall with a different request waiting.** A design that reloads its register on stall would change `out_addr` under a stalled consumer or drop the held request.
- **Low-word writes with junk in the pass-through bits.** A design that stores those bits would return them on readback.
- **Simultaneous read and write of one word.** A design with a write-first read would return the new value.
- **Random addresses with the slave-decode bits set.** A design that let those bits leak into the output would produce the wrong upper address.
- **Bypass build.** A bypass instance that still consulted the table would truncate or remap the address.

// File: rtl/pot_pkg.sv
package pot_pkg;
    // One page table entry: base keeps only bits at and above the page size.
    typedef struct packed {
        logic [63:0] base;
        logic [1:0]  space;
    } pot_entry_t;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } pot_state_t;

    localparam logic [1:0] SPACE_WIDE = 2'b01;
endpackage

// File: rtl/pot_table.sv
module pot_table
    import pot_pkg::*;
#(
    parameter int PAGE_BITS = 20,
    parameter int IDX_BITS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [IDX_BITS:0]   addr,
    input  logic [31:0]         wdata,
    output logic                rvalid,
    output logic [31:0]         rdata,
    input  logic [IDX_BITS-1:0] lk_idx,
    output pot_entry_t          lk_entry
);
    localparam int DEPTH = 1 << IDX_BITS;
    // Bits of the low word that belong to the base.
    localparam logic [31:0] LO_KEEP = ~((32'd1 << PAGE_BITS) - 32'd1);

    pot_entry_t ent_arr [DEPTH];
    logic [IDX_BITS-1:0] acc_idx;

    assign acc_idx = addr[IDX_BITS:1];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        pot_entry_t ent_q;
        logic       hit;

        assign hit = wr_en && (acc_idx == IDX_BITS'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (hit) begin
                if (addr[0]) begin
                    ent_q.base[63:32] <= wdata;
                end else begin
                    ent_q.base[31:0] <= wdata & LO_KEEP;
                    ent_q.space      <= wdata[1:0];
                end
            end
        end

        assign ent_arr[e] = ent_q;
    end

    // Lookup reads the stored contents; a write this cycle lands after the edge.
    assign lk_entry = ent_arr[lk_idx];

    logic [31:0] rd_word;
    always_comb begin
        if (addr[0]) begin
            rd_word = ent_arr[acc_idx].base[63:32];
        end else begin
            rd_word = ent_arr[acc_idx].base[31:0] | {30'd0, ent_arr[acc_idx].space};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                rdata <= rd_word;
            end
        end
    end

    // R5
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    // R5
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid && $stable(rdata));
endmodule

// File: rtl/pot_xlate.sv
module pot_xlate
    import pot_pkg::*;
#(
    parameter int IN_AW     = 32,
    parameter int PAGE_BITS = 20,
    parameter int IDX_BITS  = 4,
    parameter bit BYPASS    = 1'b0
) (
    input  logic [IN_AW-1:0]    in_addr,
    input  pot_entry_t          entry,
    output logic [IDX_BITS-1:0] idx,
    output logic [63:0]         xl_addr,
    output logic [1:0]          xl_space
);
    localparam int TOP_BIT = PAGE_BITS + IDX_BITS;

    if (BYPASS) begin : g_bypass
        always_comb begin
            idx                 = '0;
            xl_addr             = '0;
            xl_addr[IN_AW-1:0]  = in_addr;
            xl_space            = SPACE_WIDE;
        end
    end else begin : g_paged
        always_comb begin
            idx      = in_addr[TOP_BIT-1:PAGE_BITS];
            xl_addr  = {entry.base[63:PAGE_BITS], in_addr[PAGE_BITS-1:0]};
            xl_space = entry.space;
        end
    end
endmodule

// File: rtl/pot_stage.sv
module pot_stage
    import pot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [63:0] xl_addr,
    input  logic [1:0]  xl_space,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [63:0] out_addr,
    output logic [1:0]  out_space
);
    pot_state_t state_q, state_d;
    logic       accept;

    // Next state: LOAD, DRAIN, STREAM, STALL.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr  <= '0;
            out_space <= '0;
        end else if (accept) begin
            out_addr  <= xl_addr;
            out_space <= xl_space;
        end
    end

    // R7
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid && out_addr == $past(xl_addr));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_space));

    // R8
    ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready);
endmodule

// File: rtl/pot_translator.sv
module pot_translator
    import pot_pkg::*;
#(
    parameter int IN_AW     = 32,
    parameter int PAGE_BITS = 20,
    parameter int IDX_BITS  = 4,
    parameter bit BYPASS    = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [IN_AW-1:0]    in_addr,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [63:0]         out_addr,
    output logic [1:0]          out_space,
    input  logic                cfg_wr,
    input  logic                cfg_rd,
    input  logic [IDX_BITS:0]   cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic                cfg_rvalid,
    output logic [31:0]         cfg_rdata
);
    logic [IDX_BITS-1:0] lk_idx;
    pot_entry_t          lk_entry;
    logic [63:0]         xl_addr;
    logic [1:0]          xl_space;

    pot_table #(
        .PAGE_BITS (PAGE_BITS),
        .IDX_BITS  (IDX_BITS)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .rd_en    (cfg_rd),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rvalid   (cfg_rvalid),
        .rdata    (cfg_rdata),
        .lk_idx   (lk_idx),
        .lk_entry (lk_entry)
    );

    pot_xlate #(
        .IN_AW     (IN_AW),
        .PAGE_BITS (PAGE_BITS),
        .IDX_BITS  (IDX_BITS),
        .BYPASS    (BYPASS)
    ) u_xlate (
        .in_addr  (in_addr),
        .entry    (lk_entry),
        .idx      (lk_idx),
        .xl_addr  (xl_addr),
        .xl_space (xl_space)
    );

    pot_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .xl_addr   (xl_addr),
        .xl_space  (xl_space),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_space (out_space)
    );

    if (BYPASS) begin : g_chk_bypass
        // R10
        bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_ready |=> out_addr[IN_AW-1:0] == $past(in_addr) && out_space == SPACE_WIDE);
    end else begin : g_chk_paged
        // R2
        offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_ready |=> out_addr[PAGE_BITS-1:0] == $past(in_addr[PAGE_BITS-1:0]));
    end
endmodule

// File: tb/test_pot_translator.sv
`timescale 1ns/1ps
module test_pot_translator;
    localparam int N  = 20;
    localparam int IW = 4;
    localparam int Q  = 1 << IW;
    localparam logic [63:0] M64 = (64'd1 << N) - 64'd1;
    localparam logic [31:0] M32 = (32'd1 << N) - 32'd1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, in_valid, out_ready, cfg_wr, cfg_rd;
    logic [63:0] b_addr;
    logic [IW:0] cfg_addr;
    logic [31:0] cfg_wdata;

    logic        in_ready, out_valid, cfg_rvalid;
    logic [63:0] out_addr;
    logic [1:0]  out_space;
    logic [31:0] cfg_rdata;

    logic        by_ready, by_valid, by_rvalid;
    logic [63:0] by_addr;
    logic [1:0]  by_space;
    logic [31:0] by_rdata;

    pot_translator i_pot_translator (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(b_addr[31:0]),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_space(out_space),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata)
    );

    pot_translator #(.IN_AW(64), .BYPASS(1'b1)) i_pot_bypass (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(by_ready), .in_addr(b_addr),
        .out_valid(by_valid), .out_ready(out_ready),
        .out_addr(by_addr), .out_space(by_space),
        .cfg_wr(1'b0), .cfg_rd(1'b0), .cfg_addr('0),
        .cfg_wdata('0), .cfg_rvalid(by_rvalid), .cfg_rdata(by_rdata)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string ph      = "R5";

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    logic [63:0] mb [Q];
    logic [1:0]  ms [Q];
    bit          m_v, m_rv, b_v, m_rdy, b_rdy;
    logic [63:0] m_a, b_a;
    logic [1:0]  m_s;
    logic [31:0] m_rd;
    int          m_idx, c_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < Q; i++) begin
                mb[i] = '0;
                ms[i] = '0;
            end
            m_v = 0; b_v = 0; m_rv = 0; m_a = '0; b_a = '0; m_s = '0; m_rd = '0;
        end else begin
            m_rdy = !m_v || out_ready;
            b_rdy = !b_v || out_ready;
            m_idx = int'(b_addr[N+IW-1:N]);
            c_idx = int'(cfg_addr[IW:1]);
            if (in_valid && m_rdy) begin
                m_v = 1;
                m_a = (mb[m_idx] & ~M64) | ({32'd0, b_addr[31:0]} & M64);
                m_s = ms[m_idx];
            end else if (out_ready) begin
                m_v = 0;
            end
            if (in_valid && b_rdy) begin
                b_v = 1;
                b_a = b_addr;
            end else if (out_ready) begin
                b_v = 0;
            end
            m_rv = cfg_rd;
            if (cfg_rd) begin
                m_rd = cfg_addr[0] ? mb[c_idx][63:32] : (mb[c_idx][31:0] | {30'd0, ms[c_idx]});
            end
            if (cfg_wr) begin
                if (cfg_addr[0]) begin
                    mb[c_idx][63:32] = cfg_wdata;
                end else begin
                    mb[c_idx][31:0] = cfg_wdata & ~M32;
                    ms[c_idx]       = cfg_wdata[1:0];
                end
            end
        end
    end

    // Comparison away from the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk(out_valid == m_v, "R7 out_valid", 64'(out_valid), 64'(m_v));
            chk(in_ready == (!m_v || out_ready), "R8 in_ready", 64'(in_ready), 64'(!m_v || out_ready));
            if (m_v) begin
                chk(out_addr[N-1:0] == m_a[N-1:0], "R2 offset", out_addr, m_a);
                chk(out_addr[63:N] == m_a[63:N], {"R3 upper ", ph}, out_addr, m_a);
                chk(out_space == m_s, "R4 space", 64'(out_space), 64'(m_s));
            end
            chk(cfg_rvalid == m_rv, "R5 rvalid", 64'(cfg_rvalid), 64'(m_rv));
            if (m_rv) begin
                chk(cfg_rdata == m_rd, {"rdata ", ph}, 64'(cfg_rdata), 64'(m_rd));
            end
            chk(by_valid == b_v, "R10 valid", 64'(by_valid), 64'(b_v));
            if (b_v) begin
                chk(by_addr == b_a && by_space == 2'b01, "R10 addr", by_addr, b_a);
            end
        end
    end

    task automatic wr(input int idx, input bit hi, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_rd = 0; cfg_addr = {IW'(idx), hi}; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic rd(input int idx, input bit hi);
        @(negedge clk);
        cfg_rd = 1; cfg_wr = 0; cfg_addr = {IW'(idx), hi};
        @(negedge clk);
        cfg_rd = 0;
    endtask

    task automatic send(input logic [63:0] a);
        @(negedge clk);
        in_valid = 1; b_addr = a;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; in_valid = 0; out_ready = 1; cfg_wr = 0; cfg_rd = 0;
        b_addr = '0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R1 reset out_valid", 64'(out_valid), 64'd0);
        chk(in_ready == 1, "R1 reset in_ready", 64'(in_ready), 64'd1);
        rst_n = 1;

        // R1: every word reads zero after reset
        ph = "R1";
        for (int e = 0; e < Q; e++) begin
            rd(e, 0);
            rd(e, 1);
        end

        // R5: program all entries, junk in pass-through bits of low word
        ph = "R5";
        for (int e = 0; e < Q; e++) begin
            wr(e, 1, 32'h1000_0000 + e * 32'h0101_0101);
            wr(e, 0, 32'hA5A5_5A5A ^ (e << 24) ^ e);
        end
        for (int e = 0; e < Q; e += 3) begin
            rd(e, 0);
            rd(e, 1);
        end

        // R2 R3 R4: one request per entry, slave-decode bits set
        for (int e = 0; e < Q; e++) begin
            send({32'hDEAD_BEEF, 8'hF0 | 8'(e), 4'(e), 20'(e * 32'h1_2345)});
        end

        // R8: stall with a second request waiting
        ph = "R8";
        @(negedge clk);
        out_ready = 0;
        send({32'd0, 8'h00, 4'd2, 20'h0ABCD});
        @(negedge clk);
        in_valid = 1; b_addr = {32'd0, 8'h11, 4'd7, 20'h12345};
        repeat (5) @(negedge clk);
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        repeat (2) @(negedge clk);

        // R9: write entry 3 in the same cycle its request is accepted
        ph = "R9";
        @(negedge clk);
        in_valid = 1; b_addr = {32'd0, 8'h00, 4'd3, 20'h00042};
        cfg_wr = 1; cfg_addr = {4'd3, 1'b1}; cfg_wdata = 32'hCAFE_0003;
        @(negedge clk);
        cfg_wr = 0; b_addr = {32'd0, 8'h00, 4'd3, 20'h00043};
        @(negedge clk);
        in_valid = 0;
        repeat (2) @(negedge clk);

        // R6: read and write of one word in the same cycle
        ph = "R6";
        @(negedge clk);
        cfg_wr = 1; cfg_rd = 1; cfg_addr = {4'd5, 1'b0}; cfg_wdata = 32'h7777_FFFF;
        @(negedge clk);
        cfg_wr = 0; cfg_rd = 1;
        @(negedge clk);
        cfg_rd = 0;

        // Mixed random traffic
        ph = "R5";
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            in_valid  = ($urandom % 4) != 0;
            out_ready = ($urandom % 3) != 0;
            b_addr    = {$urandom, $urandom};
            cfg_wr    = ($urandom % 10) == 0;
            cfg_rd    = ($urandom % 8) == 0;
            cfg_addr  = (IW + 1)'($urandom);
            cfg_wdata = $urandom;
        end
        @(negedge clk);
        in_valid = 0; cfg_wr = 0; cfg_rd = 0; out_ready = 1;
        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule